// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out exception entry for a small in-order core. The core detects a fault and presents one request per cycle. The request holds:

- a fault kind,
- a load/store flag,
- the faulting virtual address and its address-space id,
- a coprocessor number,
- the PC and next-PC of the faulting instruction.

On the clock edge that accepts the request, the block updates the privileged state in one step: status, cause, exception PC, shadow-set control, bad address, TLB entry-high and page-context. It also issues a one-cycle redirect that carries a new PC, next-PC and next-next-PC.

The handler address depends on the EXL, BEV and IV bits as they were before the update. The exception PC is corrected when the faulting instruction sits in a branch delay slot. The shadow-set control word rotates only from normal mode. The synchronous reset is itself treated as an entry: it redirects the core to the boot address and marks coprocessor 1 usable. Software reaches all eight registers through a plain select/write/read port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `redir_valid` is 1 with PC 0xBFC00000, next-PC 0xBFC00004 and next-next-PC 0xBFC00008. Reset leaves status = 0x6 (BEV bit 1 and coprocessor-1-usable bit 2 set, EXL bit 0 clear), the base register = 0x80000000, and all other registers 0.
- R2: Every accepted request sets status bit 0 (EXL) to 1, whatever its prior value.
- R3: The shadow-set control register (select 3) has ESS in [15:12], PSS in [9:6] and CSS in [3:0]. If EXL and BEV were both 0 before an accepted entry, the old CSS moves to PSS and ESS moves to CSS. Otherwise the register is unchanged.
- R4: When PC+4 differs from next-PC, the exception PC (select 2) becomes PC-4 and cause bit 31 is set. Otherwise the exception PC becomes PC and bit 31 is cleared.
- R5: The kind code (`req_kind`) selects the exception code written to cause[6:2]. The codes are: interrupt (0) → 0, TLB modified (1) → 1, TLB invalid (2) and TLB refill (3) → 2 on load / 3 on store, address error (4) → 4 on load / 5 on store, syscall (5) → 8, breakpoint (6) → 9, reserved instruction (7) → 10, coprocessor unusable (8) → 11, overflow (9) → 12, trap (10) → 13.
- R6: Cause[29:28] takes `req_cop` on a coprocessor-unusable entry and is cleared on every other entry.
- R7: The handler is base+0x180 by default. It is base+0x000 for a TLB refill taken with EXL 0. It is base+0x200 for an interrupt taken with cause bit 23 (IV) set. The base register is select 7, and only bits [31:12] are writable.
- R8: An overflow taken with BEV 1 goes to 0xBFC00200.
- R9: `redir_valid` is high for exactly the cycle after acceptance. It carries the handler, handler+4 and handler+8.
- R10: TLB modified, invalid and refill entries set the following registers. Address errors set only the bad address. Other kinds touch none of the three.
  - bad address (select 4) = `req_vaddr`
  - entry-high (select 5) = {vaddr[31:13], 5'b0, `req_asid`}
  - context (select 6) bits [22:4] = vaddr[31:13], keeping bits [31:23]
- R11: A request is ignored in any cycle where `redir_valid` is 1, and also when its kind is 11 to 15.
- R12: `reg_sel` picks the register. `reg_rdata` shows it combinationally. A write with `reg_wr_en` updates the writable bits on the next edge. The writable bits are:
  - status [2:0]
  - cause bit 23 only
  - exception PC, all bits
  - shadow-set 0xF3CF
  - bad address, none
  - entry-high 0xFFFFE0FF
  - context [31:23]
  - base [31:12]

  A write in the same cycle as an accepted request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also reset entry |
| req_valid | input | 1 | Exception request present |
| req_kind | input | 4 | Fault kind code |
| req_store | input | 1 | 1 when the faulting access is a store |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Address-space id of the faulting access |
| req_cop | input | 2 | Coprocessor number for coprocessor-unusable |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_npc | input | 32 | Next-PC at the time of the fault |
| reg_wr_en | input | 1 | Software register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Selected register contents |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | 32 | New PC |
| redir_npc | output | 32 | New next-PC |
| redir_nnpc | output | 32 | New next-next-PC |

## Verification
Two pairs of events can fall in the same cycle.

- **A software write and an accepted entry.** The bench drives `reg_wr_en` together with `req_valid`, aimed both at a field the entry rewrites and at one it leaves alone. It then reads every register back: the entry's values must be present and the write must be absent.
- **A new request and the redirect pulse of the previous one.** The bench sends requests back to back. The second must leave no trace in the cause or exception PC, and must raise no second pulse.

A behavioural model in the bench follows both cases, together with long random mixes of kinds, mode bits and delay-slot patterns. The bench compares against the model on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN       = 32;
    localparam int INSN_BYTES = 4;

    typedef enum logic [3:0] {
        EK_INT          = 4'd0,
        EK_TLB_MOD      = 4'd1,
        EK_TLB_INV      = 4'd2,
        EK_TLB_REFILL   = 4'd3,
        EK_ADDR_ERR     = 4'd4,
        EK_SYSCALL      = 4'd5,
        EK_BREAK        = 4'd6,
        EK_RESV_INSN    = 4'd7,
        EK_COP_UNUSABLE = 4'd8,
        EK_OVERFLOW     = 4'd9,
        EK_TRAP         = 4'd10
    } exc_kind_e;

    typedef enum logic [2:0] {
        RS_STATUS  = 3'd0,
        RS_CAUSE   = 3'd1,
        RS_EPC     = 3'd2,
        RS_SRSCTL  = 3'd3,
        RS_BADVA   = 3'd4,
        RS_ENTRYHI = 3'd5,
        RS_CONTEXT = 3'd6,
        RS_EBASE   = 3'd7
    } reg_sel_e;

    localparam int NUM_REGS = 8;

    // status bits
    localparam int ST_EXL = 0;
    localparam int ST_BEV = 1;
    localparam int ST_CU1 = 2;

    // cause fields
    localparam int CA_BD     = 31;
    localparam int CA_CE_LO  = 28;
    localparam int CA_IV     = 23;
    localparam int CA_EXC_LO = 2;

    // shadow-set control fields
    localparam int SRS_W      = 4;
    localparam int SRS_CSS_LO = 0;
    localparam int SRS_PSS_LO = 6;
    localparam int SRS_ESS_LO = 12;

    // address fields
    localparam int VPN2_LO  = 13;
    localparam int VPN2_W   = XLEN - VPN2_LO;
    localparam int ASID_W   = 8;
    localparam int CTX_VPN_LO = 4;

    localparam logic [XLEN-1:0] WMASK_STATUS  = 32'h0000_0007;
    localparam logic [XLEN-1:0] WMASK_CAUSE   = 32'h0080_0000;
    localparam logic [XLEN-1:0] WMASK_EPC     = 32'hFFFF_FFFF;
    localparam logic [XLEN-1:0] WMASK_SRSCTL  = 32'h0000_F3CF;
    localparam logic [XLEN-1:0] WMASK_BADVA   = 32'h0000_0000;
    localparam logic [XLEN-1:0] WMASK_ENTRYHI = 32'hFFFF_E0FF;
    localparam logic [XLEN-1:0] WMASK_CONTEXT = 32'hFF80_0000;
    localparam logic [XLEN-1:0] WMASK_EBASE   = 32'hFFFF_F000;

    localparam logic [XLEN-1:0] BOOT_PC       = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] BEV_OVF_PC    = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] EBASE_DEFAULT = 32'h8000_0000;
    localparam logic [XLEN-1:0] OFS_GENERAL   = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFS_REFILL    = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFS_VECT_INT  = 32'h0000_0200;

    typedef struct packed {
        logic       legal;
        logic [4:0] code;
        logic       tlb_upd;
        logic       badva_upd;
        logic       is_refill;
        logic       is_int;
        logic       is_ovf;
        logic       is_cop;
    } exc_info_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] nnpc;
    } pc_triple_t;

    function automatic pc_triple_t make_triple(input logic [XLEN-1:0] base);
        pc_triple_t t;
        t.pc   = base;
        t.npc  = base + XLEN'(INSN_BYTES);
        t.nnpc = base + XLEN'(2 * INSN_BYTES);
        return t;
    endfunction

    function automatic logic [XLEN-1:0] masked_write(input logic [XLEN-1:0] old_v,
                                                     input logic [XLEN-1:0] new_v,
                                                     input logic [XLEN-1:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic [3:0] kind,
    input  logic       is_store,
    output exc_info_t  info
);
    always_comb begin
        info = '0;
        info.legal = 1'b1;
        case (kind)
            EK_INT:          begin info.code = 5'h00; info.is_int = 1'b1; end
            EK_TLB_MOD:      begin info.code = 5'h01; info.tlb_upd = 1'b1; info.badva_upd = 1'b1; end
            EK_TLB_INV:      begin info.code = is_store ? 5'h03 : 5'h02;
                                   info.tlb_upd = 1'b1; info.badva_upd = 1'b1; end
            EK_TLB_REFILL:   begin info.code = is_store ? 5'h03 : 5'h02;
                                   info.tlb_upd = 1'b1; info.badva_upd = 1'b1;
                                   info.is_refill = 1'b1; end
            EK_ADDR_ERR:     begin info.code = is_store ? 5'h05 : 5'h04; info.badva_upd = 1'b1; end
            EK_SYSCALL:      info.code = 5'h08;
            EK_BREAK:        info.code = 5'h09;
            EK_RESV_INSN:    info.code = 5'h0A;
            EK_COP_UNUSABLE: begin info.code = 5'h0B; info.is_cop = 1'b1; end
            EK_OVERFLOW:     begin info.code = 5'h0C; info.is_ovf = 1'b1; end
            EK_TRAP:         info.code = 5'h0D;
            default:         info.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
    import exc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] epc,
    output logic            in_slot
);
    logic [XLEN-1:0] seq_next;

    always_comb begin
        seq_next = pc + XLEN'(INSN_BYTES);
        in_slot  = (seq_next != npc);
        epc      = in_slot ? (pc - XLEN'(INSN_BYTES)) : pc;
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] OVF_BEV_PC = BEV_OVF_PC
) (
    input  exc_info_t       info,
    input  logic [XLEN-1:0] ebase,
    input  logic            exl_before,
    input  logic            bev_before,
    input  logic            iv_before,
    output logic [XLEN-1:0] handler
);
    always_comb begin
        if (info.is_ovf && bev_before)
            handler = OVF_BEV_PC;
        else if (info.is_refill && !exl_before)
            handler = ebase + OFS_REFILL;
        else if (info.is_int && iv_before)
            handler = ebase + OFS_VECT_INT;
        else
            handler = ebase + OFS_GENERAL;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC   = BOOT_PC,
    parameter logic [XLEN-1:0] OVF_PC     = BEV_OVF_PC,
    parameter logic [XLEN-1:0] EBASE_INIT = EBASE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic              req_store,
    input  logic [XLEN-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_cop,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_npc,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_sel,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic [XLEN-1:0]   redir_npc,
    output logic [XLEN-1:0]   redir_nnpc
);
    localparam pc_triple_t      RESET_TRIPLE = make_triple(RESET_PC);
    localparam logic [XLEN-1:0] STATUS_INIT  = XLEN'((1 << ST_BEV) | (1 << ST_CU1));

    logic [XLEN-1:0] regs_q [NUM_REGS];
    logic [XLEN-1:0] wmask  [NUM_REGS];

    exc_info_t       info;
    logic            accept;
    logic [XLEN-1:0] epc_new;
    logic            in_slot;
    logic [XLEN-1:0] handler;
    pc_triple_t      redir_q;
    logic            redir_v_q;

    logic [XLEN-1:0] status_q, cause_q, srs_q, ebase_q, ctx_q;
    logic            exl_q, bev_q, iv_q;

    assign status_q = regs_q[RS_STATUS];
    assign cause_q  = regs_q[RS_CAUSE];
    assign srs_q    = regs_q[RS_SRSCTL];
    assign ebase_q  = regs_q[RS_EBASE];
    assign ctx_q    = regs_q[RS_CONTEXT];
    assign exl_q    = status_q[ST_EXL];
    assign bev_q    = status_q[ST_BEV];
    assign iv_q     = cause_q[CA_IV];

    assign wmask[RS_STATUS]  = WMASK_STATUS;
    assign wmask[RS_CAUSE]   = WMASK_CAUSE;
    assign wmask[RS_EPC]     = WMASK_EPC;
    assign wmask[RS_SRSCTL]  = WMASK_SRSCTL;
    assign wmask[RS_BADVA]   = WMASK_BADVA;
    assign wmask[RS_ENTRYHI] = WMASK_ENTRYHI;
    assign wmask[RS_CONTEXT] = WMASK_CONTEXT;
    assign wmask[RS_EBASE]   = WMASK_EBASE;

    exc_classify u_cls (
        .kind     (req_kind),
        .is_store (req_store),
        .info     (info)
    );

    exc_epc_calc u_epc (
        .pc      (cur_pc),
        .npc     (cur_npc),
        .epc     (epc_new),
        .in_slot (in_slot)
    );

    exc_vector_sel #(.OVF_BEV_PC(OVF_PC)) u_vec (
        .info       (info),
        .ebase      (ebase_q),
        .exl_before (exl_q),
        .bev_before (bev_q),
        .iv_before  (iv_q),
        .handler    (handler)
    );

    assign accept = req_valid && !redir_v_q && info.legal;

    // next values of the registers an entry rewrites
    logic [XLEN-1:0] status_nx, cause_nx, srs_nx, entryhi_nx, ctx_nx;

    always_comb begin
        status_nx = status_q;
        status_nx[ST_EXL] = 1'b1;

        cause_nx = '0;
        cause_nx[CA_BD] = in_slot;
        cause_nx[CA_CE_LO +: 2] = info.is_cop ? req_cop : 2'b00;
        cause_nx[CA_IV] = iv_q;
        cause_nx[CA_EXC_LO +: 5] = info.code;

        srs_nx = srs_q;
        if (!exl_q && !bev_q) begin
            srs_nx[SRS_PSS_LO +: SRS_W] = srs_q[SRS_CSS_LO +: SRS_W];
            srs_nx[SRS_CSS_LO +: SRS_W] = srs_q[SRS_ESS_LO +: SRS_W];
        end

        entryhi_nx = '0;
        entryhi_nx[VPN2_LO +: VPN2_W] = req_vaddr[XLEN-1:VPN2_LO];
        entryhi_nx[ASID_W-1:0] = req_asid;

        ctx_nx = ctx_q & WMASK_CONTEXT;
        ctx_nx[CTX_VPN_LO +: VPN2_W] = req_vaddr[XLEN-1:VPN2_LO];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
            regs_q[RS_STATUS] <= STATUS_INIT;
            regs_q[RS_EBASE]  <= EBASE_INIT;
            redir_v_q <= 1'b1;
            redir_q   <= RESET_TRIPLE;
        end else begin
            redir_v_q <= accept;
            if (accept) begin
                redir_q            <= make_triple(handler);
                regs_q[RS_STATUS]  <= status_nx;
                regs_q[RS_CAUSE]   <= cause_nx;
                regs_q[RS_EPC]     <= epc_new;
                regs_q[RS_SRSCTL]  <= srs_nx;
                if (info.badva_upd) regs_q[RS_BADVA] <= req_vaddr;
                if (info.tlb_upd) begin
                    regs_q[RS_ENTRYHI] <= entryhi_nx;
                    regs_q[RS_CONTEXT] <= ctx_nx;
                end
            end else if (reg_wr_en) begin
                regs_q[reg_sel] <= masked_write(regs_q[reg_sel], reg_wdata, wmask[reg_sel]);
            end
        end
    end

    assign reg_rdata   = regs_q[reg_sel];
    assign redir_valid = redir_v_q;
    assign redir_pc    = redir_q.pc;
    assign redir_npc   = redir_q.npc;
    assign redir_nnpc  = redir_q.nnpc;

    AST_EXL_SET: assert property (@(posedge clk) disable iff (rst)
        accept |=> status_q[ST_EXL]); // R2
    AST_SRS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (accept && (exl_q || bev_q)) |=> $stable(srs_q)); // R3
    AST_CE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind != EK_COP_UNUSABLE) |=> (cause_q[CA_CE_LO +: 2] == 2'b00)); // R6
    AST_REFILL_VEC: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == EK_TLB_REFILL && !exl_q) |=> (redir_pc == $past(ebase_q))); // R7
    AST_OVF_BEV: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == EK_OVERFLOW && bev_q) |=> (redir_pc == OVF_PC)); // R8
    AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !redir_valid); // R9
    AST_REDIR_STEP: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (redir_npc - redir_pc == 32'd4 && redir_nnpc - redir_npc == 32'd4)); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && redir_valid) |=> $stable(cause_q[CA_EXC_LO +: 5])); // R11
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic        req_store = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_cop = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_npc = 32'd4;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        redir_valid;
    logic [31:0] redir_pc, redir_npc, redir_nnpc;

    always #2 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_store(req_store), .req_vaddr(req_vaddr), .req_asid(req_asid),
        .req_cop(req_cop), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .redir_npc(redir_npc), .redir_nnpc(redir_nnpc)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference model
    logic [31:0] m_reg [8];
    logic        m_rv;
    logic [31:0] m_pc;
    logic [31:0] wm [8] = '{32'h7, 32'h0080_0000, 32'hFFFF_FFFF, 32'hF3CF,
                            32'h0, 32'hFFFF_E0FF, 32'hFF80_0000, 32'hFFFF_F000};

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_reg[0] = 32'h6;
            m_reg[7] = 32'h8000_0000;
            m_rv = 1;
            m_pc = 32'hBFC0_0000;
        end else begin
            bit acc;
            acc = req_valid && !m_rv && (req_kind <= 10);
            if (acc) begin
                bit exl, bev, iv, bd;
                int code;
                logic [31:0] base;
                exl = m_reg[0][0]; bev = m_reg[0][1]; iv = m_reg[1][23];
                base = m_reg[7];
                case (req_kind)
                    0: code = 0;  1: code = 1;
                    2, 3: code = req_store ? 3 : 2;
                    4: code = req_store ? 5 : 4;
                    5: code = 8;  6: code = 9;  7: code = 10;
                    8: code = 11; 9: code = 12; default: code = 13;
                endcase
                if (req_kind == 9 && bev) m_pc = 32'hBFC0_0200;
                else if (req_kind == 3 && !exl) m_pc = base;
                else if (req_kind == 0 && iv) m_pc = base + 32'h200;
                else m_pc = base + 32'h180;
                if (!exl && !bev)
                    m_reg[3] = (m_reg[3] & 32'hF000) | ({28'd0, m_reg[3][3:0]} << 6)
                               | {28'd0, m_reg[3][15:12]};
                m_reg[0][0] = 1;
                bd = (cur_pc + 4 != cur_npc);
                m_reg[2] = bd ? cur_pc - 4 : cur_pc;
                m_reg[1] = (32'(bd) << 31) | (32'(iv) << 23) | (32'(code) << 2)
                           | ((req_kind == 8) ? (32'(req_cop) << 28) : 32'd0);
                if (req_kind >= 1 && req_kind <= 4) m_reg[4] = req_vaddr;
                if (req_kind >= 1 && req_kind <= 3) begin
                    m_reg[5] = (req_vaddr & 32'hFFFF_E000) | 32'(req_asid);
                    m_reg[6] = (m_reg[6] & 32'hFF80_0000) | ((req_vaddr >> 13) << 4);
                end
            end else if (reg_wr_en) begin
                m_reg[reg_sel] = (m_reg[reg_sel] & ~wm[reg_sel]) | (reg_wdata & wm[reg_sel]);
            end
            m_rv = acc;
        end
    end

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // compare every clock, 1 ns after the edge
    task automatic tick();
        @(posedge clk);
        #1;
        chk(redir_valid === m_rv, tag, 32'(redir_valid), 32'(m_rv));
        if (m_rv) begin
            chk(redir_pc === m_pc, tag, redir_pc, m_pc);
            chk(redir_npc === m_pc + 4 && redir_nnpc === m_pc + 8, tag, redir_nnpc, m_pc + 8);
        end
        chk(reg_rdata === m_reg[reg_sel], tag, reg_rdata, m_reg[reg_sel]);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_valid = 0; reg_wr_en = 0;
    endtask

    task automatic readall();
        idle_inputs();
        for (int s = 0; s < 8; s++) begin reg_sel = 3'(s); tick(); end
    endtask

    task automatic swr(input int s, input logic [31:0] d);
        idle_inputs();
        reg_sel = 3'(s); reg_wdata = d; reg_wr_en = 1;
        tick();
        reg_wr_en = 0;
    endtask

    task automatic exc(input int k, input bit st, input logic [31:0] pc,
                       input logic [31:0] npc, input logic [31:0] va);
        idle_inputs();
        req_valid = 1; req_kind = 4'(k); req_store = st;
        cur_pc = pc; cur_npc = npc; req_vaddr = va;
        req_asid = va[7:0] ^ 8'h5A;
        tick();
        req_valid = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        tick(); tick();
        rst = 0;
        tick();  // first cycle after reset: redirect to boot address
        chk(redir_pc === 32'hBFC0_0000, "R1 boot pc", redir_pc, 32'hBFC0_0000);
        readall();
        chk(redir_valid === 0, "R9 pulse ends", 32'(redir_valid), 0);

        tag = "R12";
        swr(7, 32'h8000_1ABC);
        swr(0, 32'h4);           // BEV=0, EXL=0
        swr(3, 32'h0000_5002);   // ESS=5, CSS=2
        swr(6, 32'hFFFF_FFFF);
        readall();

        tag = "R3";
        exc(5, 0, 32'h0000_1000, 32'h0000_1004, 0);
        chk(redir_pc === 32'h8000_1180, "R7 general", redir_pc, 32'h8000_1180);
        readall();
        tag = "R2";
        exc(6, 0, 32'h0000_2000, 32'h0000_3000, 0);  // EXL already 1, delay slot
        readall();
        tag = "R4";
        exc(13, 0, 32'h0000_2000, 32'h0000_2004, 0); // illegal kind: R11
        readall();

        tag = "R7";
        swr(0, 32'h4);
        exc(3, 0, 32'h0000_4000, 32'h0000_4004, 32'hDEAD_B123);
        chk(redir_pc === 32'h8000_1000, "R7 refill base", redir_pc, 32'h8000_1000);
        readall();
        exc(3, 1, 32'h0000_4000, 32'h0000_4004, 32'h1234_5678);
        readall();

        tag = "R10";
        exc(1, 1, 32'h100, 32'h104, 32'hCAFE_0F00);
        readall();
        exc(4, 1, 32'h200, 32'h300, 32'h0BAD_0001);
        readall();
        exc(2, 0, 32'h200, 32'h204, 32'h7777_E0E0);
        readall();

        tag = "R6";
        exc(8, 0, 32'h500, 32'h504, 0);
        req_cop = 2'd3;
        exc(8, 0, 32'h500, 32'h504, 0);
        readall();
        exc(10, 0, 32'h500, 32'h504, 0);
        readall();

        tag = "R5";
        for (int k = 0; k <= 10; k++) begin
            exc(k, 1, 32'h600, 32'h604, 32'h9000_0000);
            reg_sel = 1; tick();
        end

        tag = "R7";
        swr(1, 32'h0080_0000);   // IV=1
        exc(0, 0, 32'h700, 32'h704, 0);
        chk(redir_pc === 32'h8000_1200, "R7 vectored int", redir_pc, 32'h8000_1200);
        swr(1, 0);
        exc(0, 0, 32'h700, 32'h704, 0);

        tag = "R8";
        swr(0, 32'h2);   // BEV=1
        exc(9, 0, 32'h800, 32'h804, 0);
        chk(redir_pc === 32'hBFC0_0200, "R8 overflow bev", redir_pc, 32'hBFC0_0200);
        exc(10, 0, 32'h800, 32'h804, 0);
        swr(0, 32'h0);
        exc(9, 0, 32'h800, 32'h804, 0);
        readall();

        tag = "R11";
        idle_inputs();
        req_valid = 1; req_kind = 5; cur_pc = 32'hA00; cur_npc = 32'hA04;
        tick();
        req_kind = 7; cur_pc = 32'hB00; cur_npc = 32'hB04;  // during redirect
        tick();
        req_valid = 0;
        readall();

        tag = "R12";
        swr(0, 32'h0);
        idle_inputs();
        req_valid = 1; req_kind = 6; cur_pc = 32'hC00; cur_npc = 32'hC04;
        reg_wr_en = 1; reg_sel = 2; reg_wdata = 32'h1111_1111;
        tick();
        idle_inputs();
        readall();

        tag = "R9";
        for (int i = 0; i < 400; i++) begin
            idle_inputs();
            req_valid = ($urandom % 3) != 0;
            req_kind  = 4'($urandom % 12);
            req_store = 1'($urandom);
            req_cop   = 2'($urandom);
            req_vaddr = $urandom;
            req_asid  = 8'($urandom);
            cur_pc    = $urandom & 32'hFFFF_FFFC;
            cur_npc   = ($urandom % 2) ? cur_pc + 4 : ($urandom & 32'hFFFF_FFFC);
            reg_sel   = 3'($urandom);
            reg_wr_en = ($urandom % 4) == 0;
            reg_wdata = $urandom;
            tick();
        end
        readall();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule